// File: doc/BRIEF.md
# I2C Control and Status Register Block

This block sits between a small processor bus and the protocol engine of an I2C controller. Software updates an 8-bit control word through two write-only views. Writing ones at one address sets the matching control bits. Writing ones at another address clears them. The first address also reads back the current control word. The protocol engine never sees the bus. It receives the enable, start, stop and acknowledge bits as plain outputs, and it reports back through three signals: a one-cycle event strobe, a 5-bit bus-state code and a stop-sent pulse.

When the engine raises its event strobe, the block sets the serial interrupt flag and latches the state code into the upper five bits of a read-only status byte. The lower three bits of that byte are always zero, so the value can be used directly as an offset into a table of eight-byte handlers. The latched code stays unchanged until software clears the flag. While no interrupt is pending, the status byte reads 0xF8, which means that no state of interest is pending. The interrupt output is active while the flag is set and the interface is enabled.

Top module: `i2c_csr_block`

## Requirements
- R1: After reset the control word reads 0x00, the status byte reads 0xF8, and the interrupt output is low.
- R2: A write to address 0 sets each of control bits 2 (acknowledge), 4 (stop), 5 (start) and 6 (enable) that is one in the written byte, and leaves the other bits unchanged. A read of address 0 returns the control word, with the new value visible in the cycle after the write.
- R3: A write to address 2 clears each of control bits 2 through 6 that is one in the written byte, and leaves the other bits unchanged.
- R4: Control bits 0, 1 and 7 always read zero and ignore writes. A write to address 0 cannot set bit 3, the interrupt flag.
- R5: An engine event strobe sets bit 3 in the next cycle while the enable bit is one. A strobe is ignored while the enable bit is zero.
- R6: If an event strobe and a software clear of bit 3 fall in the same cycle, the flag stays set and the status byte takes the new code.
- R7: A read of address 1 returns the code latched when the flag was set, in bits 7:3, with bits 2:0 zero. Every 5-bit code value is kept, including 0 and 31.
- R8: While the flag stays set, later event strobes and changes of the code input leave the status byte unchanged.
- R9: Whenever the flag is zero, the status byte reads 0xF8.
- R10: A stop-sent pulse clears bit 4 in the next cycle. It takes priority over a same-cycle software set of bit 4.
- R11: The interrupt output is high exactly when both the interrupt flag and the enable bit are one.
- R12: While the enable bit is zero, bits 3, 4 and 5 are held at zero. Clearing the enable bit clears them, and writes that try to set them have no effect.
- R13: Address 3 ignores writes. Reads of addresses 2 and 3 return zero, and the read data is zero when the bus is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| eng_evt | input | 1 | Engine event strobe, one cycle |
| eng_code | input | CODE_W | Engine bus-state code |
| eng_stop_done | input | 1 | Engine has sent a STOP condition |
| irq_o | output | 1 | Interrupt request |
| ctl_en_o | output | 1 | Interface enable |
| ctl_start_o | output | 1 | Start request |
| ctl_stop_o | output | 1 | Stop request |
| ctl_ack_o | output | 1 | Assert-acknowledge |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a software clear of the interrupt flag and an engine event strobe. The second pair is a software set of the stop bit and the engine's stop-sent pulse. The bench drives both members of each pair in one bus cycle, then reads the control word and the status byte. It checks that the flag survives with the new code latched, and that the stop bit ends up cleared. It also checks that an event arriving while the interface is disabled leaves everything untouched.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

    // Control word bit positions
    localparam int ACK_B = 2;
    localparam int SI_B  = 3;
    localparam int STO_B = 4;
    localparam int STA_B = 5;
    localparam int EN_B  = 6;

    // Register addresses
    localparam int ADR_SET  = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_CLR  = 2;

    typedef struct packed {
        logic en;
        logic sta;
        logic sto;
        logic si;
        logic ack;
    } ctl_t;

endpackage

// File: rtl/i2c_csr_decode.sv
module i2c_csr_decode
    import i2c_csr_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] set_req_o,
    output logic [DATA_W-1:0] clr_req_o,
    output logic              rd_ctl_o,
    output logic              rd_stat_o
);

    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;

    always_comb begin
        set_mask        = '0;
        set_mask[ACK_B] = 1'b1;
        set_mask[STO_B] = 1'b1;
        set_mask[STA_B] = 1'b1;
        set_mask[EN_B]  = 1'b1;
        clr_mask        = set_mask;
        clr_mask[SI_B]  = 1'b1;

        set_req_o = '0;
        clr_req_o = '0;
        rd_ctl_o  = 1'b0;
        rd_stat_o = 1'b0;
        if (sel_i && wr_i) begin
            if (addr_i == ADDR_W'(ADR_SET)) set_req_o = wdata_i & set_mask;
            if (addr_i == ADDR_W'(ADR_CLR)) clr_req_o = wdata_i & clr_mask;
        end
        if (sel_i && !wr_i) begin
            rd_ctl_o  = (addr_i == ADDR_W'(ADR_SET));
            rd_stat_o = (addr_i == ADDR_W'(ADR_STAT));
        end
    end

endmodule

// File: rtl/i2c_csr_ctl.sv
module i2c_csr_ctl
    import i2c_csr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_req_i,
    input  logic [DATA_W-1:0] clr_req_i,
    input  logic              evt_i,
    input  logic              stop_done_i,
    output ctl_t              ctl_o,
    output logic              si_nxt_o,
    output logic              cap_o,
    output logic [DATA_W-1:0] word_o
);

    typedef struct packed {
        ctl_t ctl;
    } st_t;

    st_t  st_d, st_q;
    logic hw_take;
    logic sw_si_clr;

    always_comb begin
        st_d      = st_q;
        sw_si_clr = clr_req_i[SI_B];

        st_d.ctl.ack = (st_q.ctl.ack | set_req_i[ACK_B]) & ~clr_req_i[ACK_B];
        st_d.ctl.sto = (st_q.ctl.sto | set_req_i[STO_B]) & ~clr_req_i[STO_B];
        st_d.ctl.sta = (st_q.ctl.sta | set_req_i[STA_B]) & ~clr_req_i[STA_B];
        st_d.ctl.en  = (st_q.ctl.en  | set_req_i[EN_B])  & ~clr_req_i[EN_B];
        st_d.ctl.si  = st_q.ctl.si & ~sw_si_clr;

        if (stop_done_i) st_d.ctl.sto = 1'b0;

        hw_take = evt_i & st_q.ctl.en & st_d.ctl.en;
        if (hw_take) st_d.ctl.si = 1'b1;
        cap_o = hw_take & (~st_q.ctl.si | sw_si_clr);

        if (!st_d.ctl.en) begin
            st_d.ctl.sta = 1'b0;
            st_d.ctl.sto = 1'b0;
            st_d.ctl.si  = 1'b0;
        end
        si_nxt_o = st_d.ctl.si;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word_o        = '0;
        word_o[ACK_B] = st_q.ctl.ack;
        word_o[SI_B]  = st_q.ctl.si;
        word_o[STO_B] = st_q.ctl.sto;
        word_o[STA_B] = st_q.ctl.sta;
        word_o[EN_B]  = st_q.ctl.en;
    end

    assign ctl_o = st_q.ctl;

    // R5
    si_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && st_q.ctl.en && !clr_req_i[EN_B]) |=> st_q.ctl.si);

    // R6
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && st_q.ctl.en && clr_req_i[SI_B] && !clr_req_i[EN_B]) |=> st_q.ctl.si);

    // R4
    sw_si_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctl.si && !evt_i) |=> !st_q.ctl.si);

    // R10
    stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done_i |=> !st_q.ctl.sto);

    // R12
    dis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.en |-> !(st_q.ctl.sta || st_q.ctl.sto || st_q.ctl.si));

endmodule

// File: rtl/i2c_csr_stat.sv
module i2c_csr_stat #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              si_nxt_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i)          st_d.code = code_i;
        else if (!si_nxt_i) st_d.code = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.code <= '1;
        else        st_q      <= st_d;
    end

    assign code_o = st_q.code;

endmodule

// File: rtl/i2c_csr_block.sv
module i2c_csr_block
    import i2c_csr_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_evt,
    input  logic [CODE_W-1:0] eng_code,
    input  logic              eng_stop_done,
    output logic              irq_o,
    output logic              ctl_en_o,
    output logic              ctl_start_o,
    output logic              ctl_stop_o,
    output logic              ctl_ack_o
);

    localparam int ZERO_W = DATA_W - CODE_W;

    logic [DATA_W-1:0] set_req, clr_req, ctl_word;
    logic              rd_ctl, rd_stat, si_nxt, cap;
    logic [CODE_W-1:0] code_q;
    ctl_t              ctl;

    i2c_csr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .set_req_o (set_req),
        .clr_req_o (clr_req),
        .rd_ctl_o  (rd_ctl),
        .rd_stat_o (rd_stat)
    );

    i2c_csr_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req_i   (set_req),
        .clr_req_i   (clr_req),
        .evt_i       (eng_evt),
        .stop_done_i (eng_stop_done),
        .ctl_o       (ctl),
        .si_nxt_o    (si_nxt),
        .cap_o       (cap),
        .word_o      (ctl_word)
    );

    i2c_csr_stat #(.CODE_W(CODE_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .si_nxt_i (si_nxt),
        .code_i   (eng_code),
        .code_o   (code_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ctl)  bus_rdata = ctl_word;
        if (rd_stat) bus_rdata = {code_q, {ZERO_W{1'b0}}};
    end

    assign irq_o       = ctl.si & ctl.en;
    assign ctl_en_o    = ctl.en;
    assign ctl_start_o = ctl.sta;
    assign ctl_stop_o  = ctl.sto;
    assign ctl_ack_o   = ctl.ack;

    // R9
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.si |-> (code_q == {CODE_W{1'b1}}));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.si && $past(ctl.si) && !$past(cap)) |-> $stable(code_q));

endmodule

// File: tb/i2c_csr_block_test.sv
module i2c_csr_block_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       eng_evt = 1'b0, eng_stop_done = 1'b0;
    logic [4:0] eng_code = '0;
    logic       irq_o, ctl_en_o, ctl_start_o, ctl_stop_o, ctl_ack_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] q_data[$];
    logic       q_irq[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    i2c_csr_block uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_evt(eng_evt), .eng_code(eng_code), .eng_stop_done(eng_stop_done),
        .irq_o(irq_o), .ctl_en_o(ctl_en_o), .ctl_start_o(ctl_start_o),
        .ctl_stop_o(ctl_stop_o), .ctl_ack_o(ctl_ack_o)
    );

    // One bus/engine cycle: drive all inputs just after the rising edge.
    task automatic drv(input logic s, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic e, input logic [4:0] c,
                       input logic sd);
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        eng_evt = e; eng_code = c; eng_stop_done = sd;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        drv(1'b1, 1'b1, a, d, 1'b0, 5'h00, 1'b0);
    endtask

    // Driver: issue a read and push the expected result to the scoreboard.
    task automatic chk(input logic [1:0] a, input logic [7:0] d,
                       input logic irq, input string tag);
        drv(1'b1, 1'b0, a, 8'h00, 1'b0, 5'h00, 1'b0);
        q_data.push_back(d);
        q_irq.push_back(irq);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q_data.size() != 0) begin
                logic [7:0] ed;
                logic       ei;
                string      t;
                ed = q_data.pop_front();
                ei = q_irq.pop_front();
                t  = q_tag.pop_front();
                n_run++;
                if (bus_rdata !== ed || irq_o !== ei) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                             t, bus_rdata, irq_o, ed, ei);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        chk(2'd0, 8'h00, 1'b0, "R1 control after reset");
        chk(2'd1, 8'hF8, 1'b0, "R1 status after reset");

        wr(2'd0, 8'hFF);
        chk(2'd0, 8'h74, 1'b0, "R2 R4 set alias, unused and flag bits stay zero");
        wr(2'd2, 8'h24);
        chk(2'd0, 8'h50, 1'b0, "R3 clear alias start/ack");

        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 5'h00, 1'b1);
        chk(2'd0, 8'h40, 1'b0, "R10 stop-sent clears stop");
        drv(1'b1, 1'b1, 2'd0, 8'h10, 1'b0, 5'h00, 1'b1);
        chk(2'd0, 8'h40, 1'b0, "R10 stop-sent beats software set");

        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 5'h0A, 1'b0);
        chk(2'd0, 8'h48, 1'b1, "R5 R11 event sets flag, irq high");
        chk(2'd1, 8'h50, 1'b1, "R7 status holds code 0x0A");

        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 5'h11, 1'b0);
        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 5'h07, 1'b0);
        chk(2'd1, 8'h50, 1'b1, "R8 status frozen while flag set");

        drv(1'b1, 1'b1, 2'd2, 8'h08, 1'b1, 5'h03, 1'b0);
        chk(2'd0, 8'h48, 1'b1, "R6 hardware set wins over clear");
        chk(2'd1, 8'h18, 1'b1, "R6 status takes new code");

        wr(2'd2, 8'h08);
        chk(2'd1, 8'hF8, 1'b0, "R9 status idle after flag clear");
        chk(2'd0, 8'h40, 1'b0, "R11 irq low with flag clear");

        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 5'h00, 1'b0);
        chk(2'd1, 8'h00, 1'b1, "R7 code zero kept");
        wr(2'd2, 8'h08);
        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 5'h19, 1'b0);
        chk(2'd1, 8'hC8, 1'b1, "R7 code 0x19");

        wr(2'd0, 8'h20);
        chk(2'd0, 8'h68, 1'b1, "R2 start set with flag pending");
        wr(2'd2, 8'h40);
        chk(2'd0, 8'h00, 1'b0, "R12 disable clears start/stop/flag");
        chk(2'd1, 8'hF8, 1'b0, "R12 R9 status idle after disable");

        wr(2'd0, 8'h30);
        chk(2'd0, 8'h00, 1'b0, "R12 start/stop ignored while disabled");
        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 5'h05, 1'b0);
        chk(2'd0, 8'h00, 1'b0, "R5 event ignored while disabled");
        chk(2'd1, 8'hF8, 1'b0, "R5 status unchanged while disabled");

        wr(2'd3, 8'hFF);
        chk(2'd0, 8'h00, 1'b0, "R13 write to unused address ignored");
        chk(2'd3, 8'h00, 1'b0, "R13 unused address reads zero");
        chk(2'd2, 8'h00, 1'b0, "R13 clear alias reads zero");

        wr(2'd0, 8'hC7);
        chk(2'd0, 8'h44, 1'b0, "R4 bits 0,1,7 ignore writes");
        drv(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 5'h00, 1'b0);
        q_data.push_back(8'h00);
        q_irq.push_back(1'b0);
        q_tag.push_back("R13 read data zero when not selected");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule